// File: doc/BRIEF.md
# Step Attenuator Control Logic

This block is the digital front end of a 5-bit step attenuator. It takes the control pins of the attenuator (a mode select, five parallel code lines, a serial data and clock pair, a latch enable and a power-up select bit) and produces the 5-bit code that drives the switched attenuator array. Code bit 4 weighs 8 dB, bit 3 4 dB, bit 2 2 dB, bit 1 1 dB and bit 0 0.5 dB.

Three ways of setting the code are supported. In serial mode a 6-bit word is shifted in and handed on through a latch. In latched parallel mode the code lines are captured by a pulse on latch enable. In direct mode latch enable stays high and the code lines pass straight through. The latch is modelled synchronously: every pin passes through a two-flop synchronizer into the system clock domain, and edges on the serial clock and latch enable are detected there. The synchronous reset stands for power-up. During reset the pins are assumed steady, and they pick the initial code.

A serial word whose leading bit (the start bit) is 1 is never applied. The previous code stays, and a one-cycle error pulse marks the moment the latch closes on such a word.

Top module: `step_atten_ctrl`

## Requirements
- R1: With `ser_mode_i` = 1 the code comes from the serial path and the parallel lines have no effect. With `ser_mode_i` = 0 the code comes from the parallel lines and serial activity has no effect.
- R2: Each rising edge of `sclk_i` shifts `sdata_i` into a 6-bit register, whatever the level of `latch_en_i`. The word goes in MSB first: the start bit, then the 8, 4, 2, 1 and 0.5 dB bits. The 0.5 dB bit is shifted last and lands in code bit 0.
- R3: In serial mode, while `latch_en_i` is high and the start bit in the register is 0, `atten_o` follows the lower five register bits.
- R4: While `latch_en_i` is low, `atten_o` holds its value in both modes, whatever the code lines or serial inputs do.
- R5: In parallel mode, a high-then-low pulse on `latch_en_i` captures the code lines, and that code is held after the pulse.
- R6: In parallel mode with `latch_en_i` held high (direct mode), every change on `par_code_i` reaches `atten_o`.
- R7: When reset ends in serial mode, `atten_o` equals `par_code_i`.
- R8: When reset ends in parallel mode with `latch_en_i` low, `atten_o` is 0 if `pwrup_sel_i` = 0 and 5'b10000 (8 dB) if `pwrup_sel_i` = 1.
- R9: When reset ends in parallel mode with `latch_en_i` high, `atten_o` equals `par_code_i`, and `pwrup_sel_i` has no effect.
- R10: A serial word with start bit 1 is not applied: `atten_o` keeps its previous value. When latch enable falls on such a word, `start_err_o` is high for exactly one cycle.
- R11: A pin change reaches `atten_o` within three system clock cycles: two synchronizer stages plus the code register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| ser_mode_i | input | 1 | 1 selects the serial interface, 0 selects parallel |
| par_code_i | input | 5 | Parallel code lines, bit 4 = 8 dB down to bit 0 = 0.5 dB |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock, data taken on its rising edge |
| latch_en_i | input | 1 | Latch enable: high is transparent, low holds |
| pwrup_sel_i | input | 1 | Selects the power-up code in latched parallel mode |
| atten_o | output | 5 | Attenuation code to the switch array |
| start_err_o | output | 1 | One-cycle pulse when a word with start bit 1 is latched |

## Verification
Random serial words are loaded with latch enable low and then applied with a latch pulse. This separates the bit order and the shift-register holding from the latch behaviour. Other words are shifted while latch enable is high, to show that the output tracks the register. Random parallel codes are tried three ways: behind a closed latch (they must not pass), through a latch pulse (they must be captured), and with the latch held open (they must follow the lines). Between these sequences, the inactive interface of each mode is toggled. Directed cases cover all four power-up pin combinations and serial words with start bit 1, both with the latch held open and at the moment it closes.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int CODE_W = 5;
    localparam int WORD_W = CODE_W + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam code_t CODE_REF = '0;
    localparam code_t CODE_MSB = code_t'(1) << (CODE_W - 1);

    // all control pins, grouped for the synchronizer
    typedef struct packed {
        logic  ser_mode;
        code_t par;
        logic  sdata;
        logic  sclk;
        logic  le;
        logic  pup;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    // initial code chosen from the pin levels held during reset
    function automatic code_t pwrup_code(input logic ser_mode, input logic le,
                                         input logic pup, input code_t par);
        if (ser_mode || le)
            return par;
        return pup ? CODE_MSB : CODE_REF;
    endfunction

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    // during reset, preload pin levels so no false edge follows
                    if (rst) stage[0] <= d;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= d;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/atten_shreg.sv
module atten_shreg
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_s,
    input  logic  sdata_s,
    output word_t word_o
);
    logic  sclk_d;
    logic  rise;
    word_t sh_q;

    assign rise = sclk_s & ~sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= sclk_s;
            sh_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (rise)
                sh_q <= {sh_q[WORD_W-2:0], sdata_s};
        end
    end

    assign word_o = sh_q;

    // register only moves on a serial clock rise
    AST_SHIFT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(sh_q)); // R2

    // a rise needs the synchronized clock to have been low the cycle before
    AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
        rise |-> !$past(sclk_s)); // R2
endmodule

// File: rtl/atten_core.sv
module atten_core
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    // raw pins, used only while reset is high
    input  logic  ser_mode_r,
    input  logic  le_r,
    input  logic  pup_r,
    input  code_t par_r,
    // synchronized pins
    input  logic  ser_mode_s,
    input  logic  le_s,
    input  code_t par_s,
    input  word_t word_i,
    output code_t atten_o,
    output logic  start_err_o
);
    code_t atten_q;
    logic  le_d;
    logic  le_fall;
    logic  start_bad;
    logic  err_q;

    assign le_fall   = le_d & ~le_s;
    assign start_bad = word_i[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            atten_q <= pwrup_code(ser_mode_r, le_r, pup_r, par_r);
            le_d    <= le_r;
            err_q   <= 1'b0;
        end else begin
            le_d  <= le_s;
            err_q <= ser_mode_s & le_fall & start_bad;
            if (le_s) begin
                if (!ser_mode_s)
                    atten_q <= par_s;
                else if (!start_bad)
                    atten_q <= word_i[CODE_W-1:0];
            end
        end
    end

    assign atten_o     = atten_q;
    assign start_err_o = err_q;

    AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !le_s |=> $stable(atten_q)); // R4

    AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode_s && le_s) |=> (atten_q == $past(par_s))); // R6

    AST_BAD_START_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ser_mode_s && start_bad) |=> $stable(atten_q)); // R10

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err_q |=> !err_q); // R10

    AST_PWRUP_8DB: assert property (@(posedge clk)
        (rst && !ser_mode_r && !le_r && pup_r) |=> (atten_q == CODE_MSB)); // R8

    AST_PWRUP_REF: assert property (@(posedge clk)
        (rst && !ser_mode_r && !le_r && !pup_r) |=> (atten_q == CODE_REF)); // R8
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_mode_i,
    input  logic [CODE_W-1:0] par_code_i,
    input  logic              sdata_i,
    input  logic              sclk_i,
    input  logic              latch_en_i,
    input  logic              pwrup_sel_i,
    output logic [CODE_W-1:0] atten_o,
    output logic              start_err_o
);
    pins_t raw;
    pins_t syn;
    word_t word;

    assign raw = '{ser_mode: ser_mode_i, par: par_code_i, sdata: sdata_i,
                   sclk: sclk_i, le: latch_en_i, pup: pwrup_sel_i};

    atten_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    atten_shreg u_shreg (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (syn.sclk),
        .sdata_s (syn.sdata),
        .word_o  (word)
    );

    atten_core u_core (
        .clk         (clk),
        .rst         (rst),
        .ser_mode_r  (raw.ser_mode),
        .le_r        (raw.le),
        .pup_r       (raw.pup),
        .par_r       (raw.par),
        .ser_mode_s  (syn.ser_mode),
        .le_s        (syn.le),
        .par_s       (syn.par),
        .word_i      (word),
        .atten_o     (atten_o),
        .start_err_o (start_err_o)
    );

    // the select pin is never read at the edge level; unused pup after reset
    AST_SERIAL_IGNORES_PAR: assert property (@(posedge clk) disable iff (rst)
        (syn.ser_mode && !$stable(syn.par) && $stable(word)) |=> $stable(atten_o)); // R1
endmodule

// File: tb/step_atten_ctrl_test.sv
module step_atten_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_mode = 1'b0;
    logic [4:0] par = 5'd0;
    logic       sdata = 1'b0;
    logic       sclk = 1'b0;
    logic       le = 1'b0;
    logic       pup = 1'b0;
    logic [4:0] atten;
    logic       serr;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    bit done = 1'b0;
    logic [4:0] exp_code;

    always #5 clk = ~clk;

    step_atten_ctrl uut (
        .clk(clk), .rst(rst), .ser_mode_i(ser_mode), .par_code_i(par),
        .sdata_i(sdata), .sclk_i(sclk), .latch_en_i(le), .pwrup_sel_i(pup),
        .atten_o(atten), .start_err_o(serr)
    );

    always @(negedge clk) if (serr) err_seen++;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    function automatic logic [4:0] pwrup_exp(input logic m, input logic l,
                                             input logic p, input logic [4:0] c);
        if (m || l) return c;
        return p ? 5'b10000 : 5'b00000;
    endfunction

    task automatic power_up(input logic m, input logic l, input logic p, input logic [4:0] c);
        @(negedge clk);
        ser_mode = m; le = l; pup = p; par = c; sclk = 1'b0; sdata = 1'b0;
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // MSB first: start bit, then code bit 4 down to bit 0
    task automatic shift_word(input logic [5:0] w);
        for (int i = 5; i >= 0; i--) begin
            sdata = w[i];
            wait_cyc(3);
            sclk = 1'b1;
            wait_cyc(3);
            sclk = 1'b0;
            wait_cyc(3);
        end
    endtask

    task automatic le_pulse();
        le = 1'b1;
        wait_cyc(4);
        le = 1'b0;
        wait_cyc(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4305));

        // power-up cases (R7, R8, R9)
        power_up(1'b0, 1'b0, 1'b0, 5'b10110);
        check("R8 pwrup sel0", atten, 5'b00000);
        power_up(1'b0, 1'b0, 1'b1, 5'b00101);
        check("R8 pwrup sel1", atten, 5'b10000);
        power_up(1'b0, 1'b1, 1'b1, 5'b01011);
        check("R9 pwrup direct sel ignored", atten, 5'b01011);
        power_up(1'b1, 1'b0, 1'b1, 5'b11001);
        check("R7 pwrup serial", atten, 5'b11001);
        exp_code = 5'b11001;

        // R2/R4: shift with latch closed, no change; R3 after pulse
        shift_word({1'b0, 5'b00110});
        check("R4 serial shift latch closed", atten, exp_code);
        par = 5'b11111;
        wait_cyc(4);
        check("R1 serial ignores par lines", atten, exp_code);
        le_pulse();
        exp_code = 5'b00110;
        check("R2 serial word order", atten, exp_code);

        // R3 transparent tracking while latch open
        le = 1'b1;
        wait_cyc(4);
        shift_word({1'b0, 5'b10011});
        check("R3 transparent follows register", atten, 5'b10011);
        le = 1'b0;
        wait_cyc(4);
        exp_code = 5'b10011;

        // R10 bad start bit, latch pulse
        err_seen = 0;
        shift_word({1'b1, 5'b01100});
        le_pulse();
        wait_cyc(2);
        check("R10 bad start keeps code", atten, exp_code);
        check("R10 error pulse once", 5'(err_seen), 5'd1);

        // R10 bad start while open: no error until fall, code kept
        err_seen = 0;
        le = 1'b1;
        wait_cyc(4);
        check("R10 bad start open latch", atten, exp_code);
        check("R10 no error while open", 5'(err_seen), 5'd0);
        le = 1'b0;
        wait_cyc(6);
        check("R10 error on fall", 5'(err_seen), 5'd1);

        // R5 parallel latched, R1 serial ignored in parallel mode
        ser_mode = 1'b0;
        par = 5'b01010;
        wait_cyc(4);
        check("R4 parallel latch closed", atten, exp_code);
        le_pulse();
        exp_code = 5'b01010;
        check("R5 parallel pulse captures", atten, exp_code);
        le = 1'b1;
        wait_cyc(4);
        shift_word({1'b0, 5'b11100});
        check("R1 parallel ignores serial", atten, exp_code);

        // R6/R11 direct mode latency
        par = 5'b00111;
        wait_cyc(3);
        check("R11 three-cycle latency", atten, 5'b00111);
        le = 1'b0;
        exp_code = 5'b00111;
        wait_cyc(4);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int op;
            logic [4:0] c;
            op = int'($urandom % 4);
            c = 5'($urandom);
            case (op)
                0: begin
                    ser_mode = 1'b1;
                    wait_cyc(3);
                    shift_word({1'b0, c});
                    check("R4 random serial closed", atten, exp_code);
                    le_pulse();
                    exp_code = c;
                    check("R2 random serial word", atten, exp_code);
                end
                1: begin
                    ser_mode = 1'b0;
                    par = c;
                    wait_cyc(4);
                    check("R4 random parallel closed", atten, exp_code);
                    le_pulse();
                    exp_code = c;
                    check("R5 random parallel pulse", atten, exp_code);
                end
                2: begin
                    ser_mode = 1'b0;
                    le = 1'b1;
                    for (int k = 0; k < 3; k++) begin
                        par = 5'($urandom);
                        wait_cyc(3);
                        check("R6 random direct", atten, par);
                    end
                    exp_code = par;
                    le = 1'b0;
                    wait_cyc(4);
                end
                default: begin
                    ser_mode = 1'b1;
                    wait_cyc(3);
                    err_seen = 0;
                    shift_word({1'b1, c});
                    le_pulse();
                    wait_cyc(2);
                    check("R10 random bad start", atten, exp_code);
                    check("R10 random error pulse", 5'(err_seen), 5'd1);
                end
            endcase
        end

        // one more power-up with random pins
        begin
            logic [4:0] c;
            logic p;
            c = 5'($urandom);
            p = 1'($urandom);
            power_up(1'b0, 1'b0, p, c);
            check("R8 random pwrup", atten, pwrup_exp(1'b0, 1'b0, p, c));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule